// File: doc/BRIEF.md
# Serial Controller with Receive FIFO and Byte DMA

This block is a memory-mapped serial controller. A host reaches it through a word-addressed register bus. Bytes arriving on a byte-wide receive stream are kept in a circular receive FIFO. When a receive DMA is armed, they are written to memory instead. Bytes leave on a byte-wide transmit stream. A transmit DMA channel fetches them from memory, one byte at a time, through a byte-wide memory master port. A single level interrupt reports FIFO data, transmit completion and receive DMA completion.

Arming a receive DMA first moves the bytes already waiting in the FIFO to memory. The part of the requested count that was not covered by the FIFO is kept as the outstanding receive length. Later incoming bytes go to memory until that length is used up. Writing a new receive address cancels whatever length is outstanding.

While a DMA sequence runs, the sequencer owns the memory port. Host writes wait until it finishes, and so do reads of registers the sequence changes. Reads of constant or host-owned registers proceed.

Top module: `serial_dma_ctrl`

## Requirements
- R1: The register index is the bus byte address shifted right by two. Index 0 reads ID_VALUE, index 8 reads DEPTH, index 3 reads back the interrupt enable in bits 2:0, and any index above 8 reads 0.
- R2: A read of index 1 with data in the FIFO returns the oldest byte zero-extended and removes it. With the FIFO empty it returns 0xFFFFFFFF and the FIFO count stays 0.
- R3: A write of index 1 puts bus_wdata[7:0] on the transmit stream. tx_valid and tx_data hold until tx_ready is seen.
- R4: The FIFO returns bytes in arrival order across pointer wrap, and index 2 reads its count. Once it holds DEPTH bytes with no receive DMA outstanding, rx_ready is low.
- R5: Writing a non-zero count N to index 5 reads N bytes from memory, starting at the index-4 address, and transmits them in order. Afterwards index 4 reads start+N and index 5 reads 0.
- R6: Writing N to index 7 moves min(N, FIFO count) FIFO bytes to memory from the index-6 address upward. Index 6 advances by that number, and index 7 then reads N minus that number.
- R7: While index 7 is non-zero, each accepted receive byte is written to memory at the index-6 address, index 6 increments and index 7 decrements. When it is zero, received bytes go to the FIFO.
- R8: Writing index 6 clears the outstanding receive length to 0 and loads the new address, so the next received byte goes to the FIFO.
- R9: Interrupt enable bit 0 gates "FIFO not empty", bit 1 raises the interrupt unconditionally, and bit 2 gates "outstanding receive length is 0". irq is the OR of the enabled terms.
- R10: While a DMA sequence is busy, host writes and reads of indices 1, 2, 4, 5, 6 and 7 are held with bus_ready low. Reads of indices 0, 3 and 8 complete.
- R11: After synchronous reset the FIFO is empty, all addresses, lengths and enables are 0, irq and tx_valid are low, and rx_ready is high.
- R12: Read data appears on bus_rdata with bus_rvalid high in the cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Host request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted this cycle |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | bus_rdata valid |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Sink takes the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block takes the byte |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | MAW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| irq | output | 1 | Level interrupt |

## Verification
Register reads return on bus_rdata one cycle after the handshake. The bench therefore samples them at the falling edge after the accepting rising edge. irq is registered from the state, so it follows a change one cycle after the edge that made it. The bench waits three cycles before sampling irq. DMA results are never timed by counting cycles. The bench reads an address or length register, which stalls until the sequence has finished, and only then compares memory and the transmit log. Stimulus and responders change only on falling edges, so every handshake is settled before the rising edge that takes it.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [3:0] {
    IX_ID    = 4'd0,
    IX_DATA  = 4'd1,
    IX_COUNT = 4'd2,
    IX_IRQEN = 4'd3,
    IX_TXA   = 4'd4,
    IX_TXN   = 4'd5,
    IX_RXA   = 4'd6,
    IX_RXN   = 4'd7,
    IX_SIZE  = 4'd8
  } reg_ix_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_TX_FETCH,
    SQ_TX_SEND,
    SQ_RX_DRAIN,
    SQ_RX_STORE
  } seq_st_e;

  localparam int IRQ_FIFO_BIT = 0;
  localparam int IRQ_TX_BIT   = 1;
  localparam int IRQ_RX_BIT   = 2;
endpackage

// File: rtl/sdc_rx_fifo.sv
module sdc_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rd_ptr, rd_next, wr_slot;
  logic [CW-1:0] cnt;
  logic [CW:0]   slot_sum;

  assign slot_sum = (CW+1)'(rd_ptr) + (CW+1)'(cnt);
  assign wr_slot  = (slot_sum >= (CW+1)'(DEPTH)) ? PW'(slot_sum - (CW+1)'(DEPTH))
                                                 : PW'(slot_sum);

  always_comb begin
    rd_next = rd_ptr;
    if (pop) rd_next = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
  end

  // storage and look-ahead head register, no reset so block RAM fits
  always_ff @(posedge clk) begin
    if (push) store[wr_slot] <= push_data;
    head <= (push && wr_slot == rd_next) ? push_data : store[rd_next];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_next;
      cnt    <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign count = cnt;
  assign full  = (cnt == CW'(DEPTH));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r4_push_room: assert property (@(posedge clk) disable iff (rst)
    push |-> cnt < CW'(DEPTH));
  a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> cnt != '0);
endmodule

// File: rtl/sdc_irq.sv
module sdc_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] en,
  input  logic       fifo_has_data,
  input  logic       rx_pending,
  output logic       irq
);
  import sdc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (en[IRQ_FIFO_BIT] && fifo_has_data) || en[IRQ_TX_BIT] ||
                    (en[IRQ_RX_BIT] && !rx_pending);
  end

  a_r9_tx_term: assert property (@(posedge clk) disable iff (rst)
    $past(en[IRQ_TX_BIT]) |-> irq);
  a_r9_all_off: assert property (@(posedge clk) disable iff (rst)
    $past(en == 3'b000) |-> !irq);
endmodule

// File: rtl/sdc_dma_seq.sv
module sdc_dma_seq #(
  parameter int MAW  = 32,
  parameter int CNTW = 16,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_data,
  input  logic            wr_txa,
  input  logic            wr_txn,
  input  logic            wr_rxa,
  input  logic            wr_rxn,
  input  logic [31:0]     cmd_val,
  input  logic            host_wr,
  input  logic [CW-1:0]   fifo_count,
  input  logic            fifo_full,
  input  logic [7:0]      fifo_head,
  output logic            fifo_push,
  output logic            fifo_pop_dma,
  input  logic [7:0]      rx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  output logic [7:0]      tx_data,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic [MAW-1:0]  mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata,
  input  logic            mem_ack,
  output logic            busy,
  output logic            tx_free,
  output logic [MAW-1:0]  tx_addr,
  output logic [MAW-1:0]  rx_addr,
  output logic [CNTW-1:0] rx_left
);
  import sdc_pkg::*;

  seq_st_e         st;
  logic [MAW-1:0]  tx_addr_q, rx_addr_q;
  logic [CNTW-1:0] tx_left_q, rx_left_q, drain_q;
  logic [CNTW-1:0] req_n, have_n;
  logic [7:0]      tx_q, hold_q;
  logic            tx_v_q, rx_take;

  assign req_n   = CNTW'(cmd_val);
  assign have_n  = CNTW'(fifo_count);
  assign busy    = (st != SQ_IDLE);
  assign tx_free = !tx_v_q || tx_ready;
  assign rx_ready = (st == SQ_IDLE) && !host_wr && ((rx_left_q != '0) || !fifo_full);
  assign rx_take  = rx_valid && rx_ready;
  assign fifo_push    = rx_take && (rx_left_q == '0);
  assign fifo_pop_dma = (st == SQ_RX_DRAIN) && mem_ack;

  assign mem_req   = (st == SQ_TX_FETCH) || (st == SQ_RX_DRAIN) || (st == SQ_RX_STORE);
  assign mem_we    = (st == SQ_RX_DRAIN) || (st == SQ_RX_STORE);
  assign mem_addr  = (st == SQ_TX_FETCH) ? tx_addr_q : rx_addr_q;
  assign mem_wdata = (st == SQ_RX_DRAIN) ? fifo_head : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      tx_addr_q <= '0;
      rx_addr_q <= '0;
      tx_left_q <= '0;
      rx_left_q <= '0;
      drain_q   <= '0;
      tx_q      <= '0;
      hold_q    <= '0;
      tx_v_q    <= 1'b0;
    end else begin
      if (tx_v_q && tx_ready) tx_v_q <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (wr_data) begin
            tx_q   <= cmd_val[7:0];
            tx_v_q <= 1'b1;
          end
          if (wr_txa) tx_addr_q <= MAW'(cmd_val);
          if (wr_txn && req_n != '0) begin
            tx_left_q <= req_n;
            st        <= SQ_TX_FETCH;
          end
          if (wr_rxa) begin
            rx_left_q <= '0;
            rx_addr_q <= MAW'(cmd_val);
          end
          if (wr_rxn) begin
            if (have_n >= req_n) begin
              drain_q   <= req_n;
              rx_left_q <= '0;
              if (req_n != '0) st <= SQ_RX_DRAIN;
            end else begin
              drain_q   <= have_n;
              rx_left_q <= req_n - have_n;
              if (have_n != '0) st <= SQ_RX_DRAIN;
            end
          end
          if (rx_take && rx_left_q != '0) begin
            hold_q <= rx_data;
            st     <= SQ_RX_STORE;
          end
        end
        SQ_TX_FETCH: if (mem_ack) begin
          hold_q <= mem_rdata;
          st     <= SQ_TX_SEND;
        end
        SQ_TX_SEND: if (tx_free) begin
          tx_q      <= hold_q;
          tx_v_q    <= 1'b1;
          tx_addr_q <= tx_addr_q + 1'b1;
          tx_left_q <= tx_left_q - 1'b1;
          st        <= (tx_left_q == CNTW'(1)) ? SQ_IDLE : SQ_TX_FETCH;
        end
        SQ_RX_DRAIN: if (mem_ack) begin
          rx_addr_q <= rx_addr_q + 1'b1;
          drain_q   <= drain_q - 1'b1;
          if (drain_q == CNTW'(1)) st <= SQ_IDLE;
        end
        SQ_RX_STORE: if (mem_ack) begin
          rx_addr_q <= rx_addr_q + 1'b1;
          rx_left_q <= rx_left_q - 1'b1;
          st        <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign tx_data  = tx_q;
  assign tx_valid = tx_v_q;
  assign tx_addr  = tx_addr_q;
  assign rx_addr  = rx_addr_q;
  assign rx_left  = rx_left_q;

  a_r3_tx_hold: assert property (@(posedge clk) disable iff (rst)
    tx_v_q && !tx_ready |=> tx_v_q && $stable(tx_q));
  a_r6_drain_has_data: assert property (@(posedge clk) disable iff (rst)
    st == SQ_RX_DRAIN |-> fifo_count != '0);
  a_r7_store_pending: assert property (@(posedge clk) disable iff (rst)
    st == SQ_RX_STORE |-> rx_left_q != '0);
  a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
    wr_rxa |=> rx_left_q == '0);
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
endmodule

// File: rtl/serial_dma_ctrl.sv
module serial_dma_ctrl #(
  parameter int          ADDR_W   = 12,
  parameter int          DEPTH    = 16,
  parameter int          MAW      = 32,
  parameter int          CNTW     = 16,
  parameter logic [31:0] ID_VALUE = 32'h5E71_A000,
  localparam int         IXW      = ADDR_W - 2,
  localparam int         CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MAW-1:0]    mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack,
  output logic              irq
);
  import sdc_pkg::*;

  logic [IXW-1:0]  ix;
  logic            is_data, free_rd, wr_go, rd_go, busy, tx_free;
  logic            fifo_push, fifo_pop, pop_dma, pop_host, fifo_full;
  logic [CW-1:0]   fifo_count;
  logic [7:0]      fifo_head;
  logic [2:0]      int_en;
  logic [MAW-1:0]  tx_addr, rx_addr;
  logic [CNTW-1:0] rx_left;
  logic [31:0]     rd_val;
  logic            unused_lo;

  assign unused_lo = ^bus_addr[1:0];
  assign ix        = bus_addr[ADDR_W-1:2];
  assign is_data   = (ix == IXW'(IX_DATA));
  assign free_rd   = (ix == IXW'(IX_ID)) || (ix == IXW'(IX_IRQEN)) ||
                     (ix == IXW'(IX_SIZE)) || (ix > IXW'(IX_SIZE));
  assign bus_ready = bus_valid && (bus_write ? (!busy && (!is_data || tx_free))
                                             : (!busy || free_rd));
  assign wr_go     = bus_ready && bus_write;
  assign rd_go     = bus_ready && !bus_write;
  assign pop_host  = rd_go && is_data && (fifo_count != '0);
  assign fifo_pop  = pop_host || pop_dma;

  always_ff @(posedge clk) begin
    if (rst) int_en <= '0;
    else if (wr_go && ix == IXW'(IX_IRQEN)) int_en <= bus_wdata[2:0];
  end

  always_comb begin
    rd_val = '0;
    case (ix)
      IXW'(IX_ID):    rd_val = ID_VALUE;
      IXW'(IX_DATA):  rd_val = (fifo_count != '0) ? {24'h0, fifo_head} : 32'hFFFF_FFFF;
      IXW'(IX_COUNT): rd_val = 32'(fifo_count);
      IXW'(IX_IRQEN): rd_val = {29'h0, int_en};
      IXW'(IX_TXA):   rd_val = 32'(tx_addr);
      IXW'(IX_TXN):   rd_val = '0;
      IXW'(IX_RXA):   rd_val = 32'(rx_addr);
      IXW'(IX_RXN):   rd_val = 32'(rx_left);
      IXW'(IX_SIZE):  rd_val = 32'(DEPTH);
      default:        rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_go;
      if (rd_go) bus_rdata <= rd_val;
    end
  end

  sdc_rx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst(rst), .push(fifo_push), .push_data(rx_data),
    .pop(fifo_pop), .head(fifo_head), .count(fifo_count), .full(fifo_full)
  );

  sdc_dma_seq #(.MAW(MAW), .CNTW(CNTW), .CW(CW)) u_seq (
    .clk(clk), .rst(rst),
    .wr_data(wr_go && is_data),
    .wr_txa(wr_go && ix == IXW'(IX_TXA)),
    .wr_txn(wr_go && ix == IXW'(IX_TXN)),
    .wr_rxa(wr_go && ix == IXW'(IX_RXA)),
    .wr_rxn(wr_go && ix == IXW'(IX_RXN)),
    .cmd_val(bus_wdata), .host_wr(bus_valid && bus_write),
    .fifo_count(fifo_count), .fifo_full(fifo_full), .fifo_head(fifo_head),
    .fifo_push(fifo_push), .fifo_pop_dma(pop_dma),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .busy(busy), .tx_free(tx_free), .tx_addr(tx_addr), .rx_addr(rx_addr),
    .rx_left(rx_left)
  );

  sdc_irq u_irq (
    .clk(clk), .rst(rst), .en(int_en), .fifo_has_data(fifo_count != '0),
    .rx_pending(rx_left != '0), .irq(irq)
  );

  a_r10_stall_wr: assert property (@(posedge clk) disable iff (rst)
    busy && bus_valid && bus_write |-> !bus_ready);
  a_r12_rvalid: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> bus_rvalid);
  a_r2_empty_keep: assert property (@(posedge clk) disable iff (rst)
    rd_go && is_data && fifo_count == '0 && !fifo_push |=> fifo_count == '0);
endmodule

// File: tb/test_serial_dma_ctrl.sv
module test_serial_dma_ctrl;
  localparam int DEPTH = 16;
  localparam logic [31:0] IDV = 32'h5E71_A000;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_rvalid;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data, rx_data = '0, mem_wdata, mem_rdata = '0;
  logic        tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  logic        mem_req, mem_we, mem_ack = 1'b0, irq;
  logic [31:0] mem_addr;

  always #5 clk = ~clk;

  serial_dma_ctrl #(.DEPTH(DEPTH), .ID_VALUE(IDV)) i_serial_dma_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  bit last_rvalid = 0;
  logic [7:0] mem_img [256];
  logic [7:0] tx_log [64];
  int tx_n = 0;
  int tx_mode = 2;
  logic [7:0] mq [$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: one idle cycle, then ack
  always @(negedge clk) begin
    if (rst) mem_ack = 1'b0;
    else if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_we) mem_img[mem_addr[7:0]] = mem_wdata;
      else        mem_rdata = mem_img[mem_addr[7:0]];
    end
  end

  // transmit sink
  always @(negedge clk) begin
    if (rst) tx_ready = 1'b0;
    else case (tx_mode)
      0:       tx_ready = 1'b0;
      1:       tx_ready = 1'($urandom_range(0, 1));
      default: tx_ready = 1'b1;
    endcase
    if (!rst && tx_valid && tx_ready) begin
      if (tx_n < 64) tx_log[tx_n] = tx_data;
      tx_n++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_xfer(input bit wr, input int idx, input logic [31:0] wd,
                          output logic [31:0] rd);
    bit got = 0;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = 12'(idx * 4); bus_wdata = wd;
    while (!got) begin
      #1 got = bus_ready;
      @(negedge clk);
    end
    bus_valid = 1'b0; bus_write = 1'b0;
    rd = bus_rdata;
    last_rvalid = bus_rvalid;
  endtask

  task automatic wr(input int idx, input logic [31:0] wd);
    logic [31:0] d;
    bus_xfer(1'b1, idx, wd, d);
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    bus_xfer(1'b0, idx, 32'h0, d);
  endtask

  task automatic rx_send(input logic [7:0] b);
    bit got = 0;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!got) begin
      #1 got = rx_ready;
      @(negedge clk);
    end
    rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_pop(inout logic [7:0] q [$]);
    if (q.size() == 0) return 32'hFFFF_FFFF;
    return {24'h0, q.pop_front()};
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e;
    logic [7:0] b;
    bit stall_ok;
    int op;
    void'($urandom(32'd7));
    for (int i = 0; i < 256; i++) mem_img[i] = 8'(i) ^ 8'h3C;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    check("R11", "irq", 32'(irq), 0);
    check("R11", "tx_valid", 32'(tx_valid), 0);
    check("R11", "rx_ready", 32'(rx_ready), 1);
    rd(2, d); check("R11", "count", d, 0);
    rd(6, d); check("R11", "rx addr", d, 0);
    rd(7, d); check("R11", "rx left", d, 0);
    rd(4, d); check("R11", "tx addr", d, 0);
    check("R12", "rvalid after read", 32'(last_rvalid), 1);
    // R1 decode
    rd(0, d); check("R1", "id", d, IDV);
    rd(8, d); check("R1", "size", d, DEPTH);
    rd(11, d); check("R1", "unmapped", d, 0);
    wr(3, 32'hFFFF_FFF5); rd(3, d); check("R1", "irq enable readback", d, 5);
    wr(3, 0);
    // R2 empty read
    rd(1, d); check("R2", "empty data", d, 32'hFFFF_FFFF);
    rd(2, d); check("R2", "count after empty read", d, 0);
    // R3 direct transmit
    tx_n = 0;
    wr(1, 32'h1234_56A5);
    idle(4);
    check("R3", "tx count", tx_n, 1);
    check("R3", "tx byte", 32'(tx_log[0]), 32'hA5);
    // R4 random FIFO traffic with wrap
    for (int it = 0; it < 80; it++) begin
      op = int'($urandom_range(0, 2));
      if (op != 0 && mq.size() < DEPTH) begin
        b = 8'($urandom);
        rx_send(b);
        mq.push_back(b);
      end else begin
        e = exp_pop(mq);
        rd(1, d);
        check("R4", "fifo order", d, e);
      end
      if (it % 10 == 9) begin
        rd(2, d); check("R4", "fifo count", d, mq.size());
      end
    end
    while (mq.size() < DEPTH) begin
      b = 8'($urandom);
      rx_send(b);
      mq.push_back(b);
    end
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'hEE;
    #1 check("R4", "rx_ready when full", 32'(rx_ready), 0);
    @(negedge clk); rx_valid = 1'b0;
    while (mq.size() > 0) begin
      e = exp_pop(mq);
      rd(1, d); check("R4", "full drain order", d, e);
    end
    // R9 interrupt
    wr(3, 1); idle(3); check("R9", "fifo term empty", 32'(irq), 0);
    rx_send(8'h11); mq.push_back(8'h11);
    idle(3); check("R9", "fifo term data", 32'(irq), 1);
    e = exp_pop(mq); rd(1, d); check("R2", "pop", d, e);
    idle(3); check("R9", "fifo term drained", 32'(irq), 0);
    wr(3, 2); idle(3); check("R9", "tx term", 32'(irq), 1);
    wr(3, 4); idle(3); check("R9", "rx term idle", 32'(irq), 1);
    wr(3, 0); idle(3); check("R9", "none", 32'(irq), 0);
    // R5 transmit DMA
    for (int i = 0; i < 6; i++) mem_img[8'h40 + i] = 8'($urandom);
    tx_mode = 1; tx_n = 0;
    wr(4, 32'h40); wr(5, 6);
    rd(4, d); check("R5", "tx addr end", d, 32'h46);
    rd(5, d); check("R5", "tx count read", d, 0);
    idle(20);
    check("R5", "tx bytes", tx_n, 6);
    for (int i = 0; i < 6; i++)
      check("R5", "tx byte", 32'(tx_log[i]), 32'(mem_img[8'h40 + i]));
    // R10 stall behaviour
    tx_mode = 0; tx_n = 0;
    wr(4, 32'h50); wr(5, 2);
    rd(0, d); check("R10", "id read while busy", d, IDV);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'(2 * 4);
    stall_ok = 1;
    for (int i = 0; i < 8; i++) begin
      #1 if (bus_ready) stall_ok = 0;
      @(negedge clk);
    end
    bus_valid = 1'b0;
    check("R10", "count read held while busy", 32'(stall_ok), 1);
    tx_mode = 2;
    rd(4, d); check("R10", "tx addr after release", d, 32'h52);
    idle(6);
    check("R10", "bytes after release", tx_n, 2);
    // R6 receive drain
    for (int i = 0; i < 3; i++) begin
      b = 8'($urandom); rx_send(b); mq.push_back(b);
    end
    wr(6, 32'h80); wr(7, 5);
    rd(7, d); check("R6", "rx left", d, 2);
    rd(6, d); check("R6", "rx addr", d, 32'h83);
    rd(2, d); check("R6", "fifo emptied", d, 0);
    for (int i = 0; i < 3; i++) begin
      e = exp_pop(mq);
      check("R6", "drained byte", 32'(mem_img[8'h80 + i]), e);
    end
    wr(3, 4); idle(3); check("R9", "rx term pending", 32'(irq), 0);
    // R7 direct receive to memory
    rx_send(8'hC0); rx_send(8'hC1);
    rd(7, d); check("R7", "rx left used", d, 0);
    rd(6, d); check("R7", "rx addr", d, 32'h85);
    check("R7", "mem 0x83", 32'(mem_img[8'h83]), 32'hC0);
    check("R7", "mem 0x84", 32'(mem_img[8'h84]), 32'hC1);
    idle(3); check("R9", "rx term done", 32'(irq), 1);
    rx_send(8'hC2);
    rd(2, d); check("R7", "back to fifo", d, 1);
    rd(1, d); check("R7", "fifo byte", d, 32'hC2);
    // R8 cancel
    wr(7, 4);
    rd(7, d); check("R8", "armed", d, 4);
    wr(6, 32'hC0);
    rd(7, d); check("R8", "cancelled", d, 0);
    rd(6, d); check("R8", "new addr", d, 32'hC0);
    rx_send(8'h5A);
    rd(2, d); check("R8", "byte to fifo", d, 1);
    check("R8", "mem untouched", 32'(mem_img[8'hC0]), 32'(8'hC0 ^ 8'h3C));
    rd(1, d); check("R8", "fifo byte", d, 32'h5A);
    wr(3, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule